// File: doc/BRIEF.md
# Cascaded Configurable Interrupt Controller

This block gathers 96 interrupt request lines into one processor interrupt. The lines form three banks of 32: a main bank (global sources 0 to 31) and two sub-banks (global sources 32 to 63 and 64 to 95). Each source has its own sense and trigger settings. The sense setting picks active-high or active-low. The trigger setting picks level or edge. Each source also has an enable bit.

A sub-bank's combined pending signal feeds a fixed input of the main bank. A sub-bank source therefore reaches the processor only through the main bank. The block reports the global number of the source to service next. It chooses the highest-numbered pending main-bank bit. When that bit is a cascade slot, it then chooses the highest-numbered pending bit of the sub-bank behind that slot.

Software uses a flat register port. A write strobe, a bank number and a register selector address the registers. Reads are combinational. Latched edge events are cleared by writing ones to the raw-status register.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset all enable bits, trigger bits and edge latches are 0, all sense bits are 1, and irq_o and irq_idx_o are 0.
- R2: reg_bank selects bank 0 (main), 1 (sub A) or 2 (sub B). reg_rdata combinationally returns the register chosen by reg_sel: 0 enable, 1 raw status, 2 masked status, 3 sense, 4 trigger. Any other selector code, and bank 3, read as 0.
- R3: For a level source (trigger bit 0), the raw bit equals the input when its sense bit is 1 and the inverted input when it is 0. It reflects an input change after two rising clock edges.
- R4: For an edge source (trigger bit 1), a rising edge (sense 1) or a falling edge (sense 0) on the input sets the raw bit three clock edges after the change. The bit stays set after the input returns. The opposite edge sets nothing.
- R5: Writing the raw-status register clears the edge latches at the bit positions written as 1 and leaves those written as 0. A level source's raw bit is unaffected. A new edge detected in the same cycle as the clear keeps the bit set.
- R6: The masked status is the raw status ANDed with the enable bits. irq_o is 1 exactly when any main-bank masked bit is 1.
- R7: Main-bank bit 0 carries the OR of sub-bank A's masked status, and bit 1 carries that of sub-bank B. These two bits behave as active-high level inputs regardless of their sense and trigger bits. The irq_in lines 0 and 1 are ignored.
- R8: While irq_o is 1, irq_idx_o gives the highest-numbered set main-bank masked bit. When that bit is 0 or 1, irq_idx_o gives 32 or 64 plus the highest-numbered set masked bit of sub-bank A or B respectively. While irq_o is 0, irq_idx_o is 0.
- R9: Writing the sense or trigger register clears the edge latch of every bit whose value the write changes. Bits written with an unchanged value keep their latch.
- R10: Writes to the masked-status selector, to unused selector codes, or to bank 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| irq_in | input | 96 | Request lines, bit n is global source n |
| reg_we | input | 1 | Register write strobe |
| reg_bank | input | 2 | Bank number for access |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Processor interrupt request |
| irq_idx_o | output | 7 | Global number of the source to service |

## Verification
The embedded properties are checked every cycle. They cover four behaviours. A clear by ones leaves no latch set unless a new edge arrived. A reconfiguration leaves no latch at a changed bit. Latches never set for level sources. A reported sub-bank A number implies an enabled cascade slot with sub-bank A pending. The properties also check that the index is zero while idle.

Only the bench's scenarios can show several behaviours. These are the input-to-status latency and the sense inversion on every one of the 96 lines. They also include rising versus falling capture, hold after the input returns, and the race between a clear and a new edge. The remaining ones are the exact two-level index across sub-bank sweeps and the ignoring of the main-bank lines replaced by the cascade.

// File: rtl/casc_irq_ctrl.sv
`timescale 1ns/1ps
module casc_irq_ctrl #(
  parameter int NSRC   = 32,
  parameter int SLOT_A = 0,
  parameter int SLOT_B = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [3*NSRC-1:0]               irq_in,
  input  logic                            reg_we,
  input  logic [1:0]                      reg_bank,
  input  logic [2:0]                      reg_sel,
  input  logic [NSRC-1:0]                 reg_wdata,
  output logic [NSRC-1:0]                 reg_rdata,
  output logic                            irq_o,
  output logic [$clog2(3*NSRC)-1:0]       irq_idx_o
);
  localparam int NB = 3;
  localparam int IW = $clog2(NSRC);
  localparam int GW = $clog2(NB*NSRC);
  localparam logic [2:0] SEL_EN = 3'd0, SEL_RAW = 3'd1, SEL_MSK = 3'd2,
                         SEL_POL = 3'd3, SEL_TYP = 3'd4;
  localparam logic [NSRC-1:0] SLOT_MASK = (NSRC'(1) << SLOT_A) | (NSRC'(1) << SLOT_B);

  logic [NB-1:0][NSRC-1:0] en_q, pol_q, typ_q, lat_q, s1_q, s2_q, s3_q;
  logic [NB-1:0][NSRC-1:0] raw_pre, raw, msk, edge_set, lat_d;
  logic [NB-1:0]           wr_b;
  logic                    casc_a, casc_b;

  function automatic logic [IW-1:0] hi_bit(input logic [NSRC-1:0] v);
    hi_bit = '0;
    for (int i = 0; i < NSRC; i++) if (v[i]) hi_bit = IW'(i);
  endfunction

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      logic [NSRC-1:0] w1c, cfg;
      wr_b[b]     = reg_we && (reg_bank == 2'(b));
      raw_pre[b]  = (typ_q[b] & lat_q[b]) | (~typ_q[b] & ~(s2_q[b] ^ pol_q[b]));
      edge_set[b] = typ_q[b] & ((pol_q[b] & s2_q[b] & ~s3_q[b]) |
                                (~pol_q[b] & ~s2_q[b] & s3_q[b]));
      w1c = (wr_b[b] && reg_sel == SEL_RAW) ? reg_wdata : '0;
      cfg = ((wr_b[b] && reg_sel == SEL_POL) ? (reg_wdata ^ pol_q[b]) : '0) |
            ((wr_b[b] && reg_sel == SEL_TYP) ? (reg_wdata ^ typ_q[b]) : '0);
      lat_d[b] = ((lat_q[b] & ~w1c) | edge_set[b]) & ~cfg;
    end
  end

  assign casc_a = |(raw_pre[1] & en_q[1]);
  assign casc_b = |(raw_pre[2] & en_q[2]);

  always_comb begin
    raw    = raw_pre;
    raw[0] = (raw_pre[0] & ~SLOT_MASK) | ({{(NSRC-1){1'b0}}, casc_a} << SLOT_A)
                                       | ({{(NSRC-1){1'b0}}, casc_b} << SLOT_B);
  end

  assign msk   = raw & en_q;
  assign irq_o = |msk[0];

  always_comb begin
    logic [IW-1:0] top;
    top = hi_bit(msk[0]);
    if (!irq_o)                   irq_idx_o = '0;
    else if (top == IW'(SLOT_A))  irq_idx_o = GW'(NSRC)   + GW'(hi_bit(msk[1]));
    else if (top == IW'(SLOT_B))  irq_idx_o = GW'(2*NSRC) + GW'(hi_bit(msk[2]));
    else                          irq_idx_o = GW'(top);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_bank < 2'(NB)) begin
      case (reg_sel)
        SEL_EN:  reg_rdata = en_q[reg_bank];
        SEL_RAW: reg_rdata = raw[reg_bank];
        SEL_MSK: reg_rdata = msk[reg_bank];
        SEL_POL: reg_rdata = pol_q[reg_bank];
        SEL_TYP: reg_rdata = typ_q[reg_bank];
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      en_q  <= '0;
      pol_q <= '1;
      typ_q <= '0;
      lat_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      s3_q  <= '0;
    end else begin
      s1_q  <= irq_in;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      lat_q <= lat_d;
      for (int b = 0; b < NB; b++) begin
        if (wr_b[b]) begin
          case (reg_sel)
            SEL_EN:  en_q[b]  <= reg_wdata;
            SEL_POL: pol_q[b] <= reg_wdata;
            SEL_TYP: typ_q[b] <= reg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_chk
    a_r5_clear_sticks: assert property (@(posedge clk) disable iff (rst)
      (wr_b[b] && reg_sel == SEL_RAW) |=>
        ((lat_q[b] & $past(reg_wdata) & ~$past(edge_set[b])) == '0));
    a_r9_cfg_clears: assert property (@(posedge clk) disable iff (rst)
      (wr_b[b] && reg_sel == SEL_POL) |=>
        ((lat_q[b] & ($past(reg_wdata) ^ $past(pol_q[b]))) == '0));
    a_r4_edge_only: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((lat_q[b] & ~$past(lat_q[b]) & ~$past(typ_q[b])) == '0));
  end

  a_r8_idle_idx: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> irq_idx_o == '0);
  a_r7_sub_a_path: assert property (@(posedge clk) disable iff (rst)
    (irq_o && irq_idx_o >= GW'(NSRC) && irq_idx_o < GW'(2*NSRC)) |->
      (en_q[0][SLOT_A] && (|(raw[1] & en_q[1]))));
endmodule

// File: tb/tb_casc_irq_ctrl.sv
`timescale 1ns/1ps
module tb_casc_irq_ctrl;
  logic        clk = 0, rst = 1;
  logic [95:0] irq_in = '0;
  logic        reg_we = 0;
  logic [1:0]  reg_bank = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq_o;
  logic [6:0]  irq_idx_o;
  int nvec = 0, nfail = 0;
  bit done = 0;

  casc_irq_ctrl dut (.clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we),
    .reg_bank(reg_bank), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .irq_idx_o(irq_idx_o));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int bank, input int sel, input logic [31:0] d);
    reg_bank = 2'(bank); reg_sel = 3'(sel); reg_wdata = d; reg_we = 1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rchk(input int bank, input int sel, input logic [31:0] exp, input string tag);
    reg_bank = 2'(bank); reg_sel = 3'(sel);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R1 act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 / R2 reset state and selector decode
    for (int b = 0; b < 3; b++) begin
      rchk(b, 0, 32'h0, "R1 enable");
      rchk(b, 1, 32'h0, "R1 raw");
      rchk(b, 2, 32'h0, "R1 masked");
      rchk(b, 3, 32'hFFFF_FFFF, "R1 sense");
      rchk(b, 4, 32'h0, "R1 trigger");
      rchk(b, 6, 32'h0, "R2 unused selector");
    end
    rchk(3, 3, 32'h0, "R2 bank3 read");
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 idx", 32'(irq_idx_o), 0);

    // R3 level sweep, both senses, every line; R7 main lines 0/1 ignored
    for (int pass = 0; pass < 2; pass++) begin
      for (int b = 0; b < 3; b++) wr(b, 3, pass == 0 ? 32'hFFFF_FFFF : 32'h0);
      for (int b = 0; b < 3; b++) begin
        for (int i = 0; i < 32; i++) begin
          logic [31:0] oh, keep;
          oh = 32'h1 << i;
          keep = (b == 0) ? 32'hFFFF_FFFC : 32'hFFFF_FFFF;
          irq_in = '0;
          irq_in[32*b +: 32] = oh;
          settle(2);
          rchk(b, 1, (pass == 0 ? oh : ~oh) & keep, "R3 level raw");
        end
      end
    end
    for (int b = 0; b < 3; b++) wr(b, 3, 32'hFFFF_FFFF);
    irq_in = '0;
    settle(3);

    // R4 / R5 rising edges on sub-bank A
    wr(1, 4, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      irq_in[32+i] = 1; settle(3);
      rchk(1, 1, 32'h1 << i, "R4 rising capture");
      irq_in[32+i] = 0; settle(3);
      rchk(1, 1, 32'h1 << i, "R4 hold after release");
      wr(1, 1, 32'h0);
      rchk(1, 1, 32'h1 << i, "R5 zero write no effect");
      wr(1, 1, 32'h1 << i);
      rchk(1, 1, 32'h0, "R5 clear by one");
    end

    // R4 falling edges on sub-bank B
    irq_in[95:64] = '1; settle(3);
    wr(2, 4, 32'hFFFF_FFFF);
    wr(2, 3, 32'h0);
    rchk(2, 1, 32'h0, "R4 falling idle");
    for (int i = 0; i < 32; i++) begin
      irq_in[64+i] = 0; settle(3);
      rchk(2, 1, 32'h1 << i, "R4 falling capture");
      irq_in[64+i] = 1; settle(3);
      rchk(2, 1, 32'h1 << i, "R4 rising ignored");
      wr(2, 1, 32'h1 << i);
      rchk(2, 1, 32'h0, "R5 clear falling");
    end
    wr(2, 3, 32'hFFFF_FFFF);
    wr(2, 4, 32'h0);
    irq_in[95:64] = '0; settle(3);
    rchk(2, 1, 32'h0, "R3 level back");

    // R9 reconfiguration
    irq_in[37] = 1; settle(3); irq_in[37] = 0; settle(3);
    rchk(1, 1, 32'h20, "R9 latch set");
    wr(1, 3, 32'hFFFF_FFFF);
    rchk(1, 1, 32'h20, "R9 unchanged sense keeps");
    wr(1, 3, ~32'h20);
    rchk(1, 1, 32'h0, "R9 sense change clears");
    wr(1, 3, 32'hFFFF_FFFF);
    irq_in[38] = 1; settle(3); irq_in[38] = 0; settle(3);
    rchk(1, 1, 32'h40, "R9 latch set 2");
    wr(1, 4, ~32'h40);
    rchk(1, 1, 32'h0, "R9 trigger change clears");
    wr(1, 4, 32'hFFFF_FFFF);
    rchk(1, 1, 32'h0, "R9 no revival");

    // R5 clear racing a new edge
    irq_in[39] = 1; settle(3); irq_in[39] = 0; settle(3);
    rchk(1, 1, 32'h80, "R5 race setup");
    irq_in[39] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(1, 1, 32'h80);
    rchk(1, 1, 32'h80, "R5 new edge wins");
    irq_in[39] = 0; settle(3);
    wr(1, 1, 32'h80);
    rchk(1, 1, 32'h0, "R5 later clear");
    wr(1, 4, 32'h0);

    // R6 / R8 main bank
    wr(0, 0, 32'hFFFF_FFFF);
    for (int i = 2; i < 32; i++) begin
      irq_in = '0; irq_in[i] = 1; settle(2);
      chk("R6 irq single", 32'(irq_o), 1);
      chk("R8 idx single", 32'(irq_idx_o), i);
      rchk(0, 2, 32'h1 << i, "R6 masked single");
      irq_in[2] = 1; irq_in[31 - (i % 30)] = 1; settle(2);
      chk("R8 idx multi", 32'(irq_idx_o), (i > 31 - (i % 30)) ? i : 31 - (i % 30));
    end
    irq_in = '0; irq_in[1:0] = 2'b11; settle(2);
    chk("R7 main lines 0/1 ignored", 32'(irq_o), 0);
    irq_in = '0; irq_in[9] = 1;
    wr(0, 0, ~32'h200); settle(2);
    chk("R6 disabled source", 32'(irq_o), 0);
    rchk(0, 1, 32'h200, "R6 raw still pending");
    rchk(0, 2, 32'h0, "R6 masked empty");
    irq_in = '0;
    wr(0, 0, 32'hFFFF_FFFF);

    // R7 / R8 cascade
    wr(1, 0, 32'hFFFF_FFFF);
    wr(2, 0, 32'hFFFF_FFFF);
    for (int k = 0; k < 32; k++) begin
      irq_in = '0; irq_in[32+k] = 1; settle(2);
      chk("R8 sub A idx", 32'(irq_idx_o), 32 + k);
      rchk(0, 1, 32'h1, "R7 slot A raw");
      irq_in = '0; irq_in[64+k] = 1; settle(2);
      chk("R8 sub B idx", 32'(irq_idx_o), 64 + k);
      irq_in[32+k] = 1; irq_in[64+k] = 0; irq_in[64+31-k] = 1; settle(2);
      chk("R8 B over A", 32'(irq_idx_o), 64 + 31 - k);
      irq_in[4] = 1; settle(2);
      chk("R8 main over cascade", 32'(irq_idx_o), 4);
    end
    irq_in = '0; irq_in[35] = 1; irq_in[52] = 1; settle(2);
    chk("R8 highest in sub A", 32'(irq_idx_o), 52);
    wr(0, 0, ~32'h1); settle(1);
    chk("R7 slot A disabled", 32'(irq_o), 0);
    chk("R8 idle idx", 32'(irq_idx_o), 0);
    irq_in = '0;

    // R10 ignored writes
    wr(0, 2, 32'h0);
    rchk(0, 0, ~32'h1, "R10 masked write ignored");
    wr(1, 5, 32'h0);
    rchk(1, 0, 32'hFFFF_FFFF, "R10 unused selector write");
    wr(3, 0, 32'h0);
    wr(3, 3, 32'h0);
    rchk(0, 0, ~32'h1, "R10 bank3 write en0");
    rchk(2, 0, 32'hFFFF_FFFF, "R10 bank3 write en2");
    rchk(2, 3, 32'hFFFF_FFFF, "R10 bank3 write sense");
    rchk(3, 0, 32'h0, "R2 bank3 reads zero");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule